// File: doc/BRIEF.md
# Mode-Programmable Byte Port with Service Request

This block is a parallel byte port whose single data register and single service-request flag serve either direction of transfer. A static `mode` pin picks the role. In the input role, a peripheral pulses the strobe to capture a byte, and the service request tells the host that a byte is waiting. The host then selects the port to read the byte on the data outputs, and deselecting the port releases the request. In the output role, the host writes the register by selecting the port and pulsing the strobe. Deselecting the port then raises the service request, which tells the peripheral that a byte is ready. The peripheral's next strobe falling edge acknowledges it.

The strobe and both selects are asynchronous to the system clock. Each passes through a synchronizer chain of `SYNC_STAGES` flops, and a falling strobe edge is detected as a one-cycle pulse after that chain. The tristate drivers appear as the `dout` bus plus the `dout_oe` enable. The active-low clear is asynchronous. Mode is treated as static; change it only while clear is held.

Top module: `byte_port`

## Requirements
- R1: Mode 0 selects the input role and mode 1 selects the output role. Select 2 is active high in both roles. Select 1 is active high in the input role and active low in the output role.
- R2: In the input role, the register follows `din` while the synchronized strobe is high, with no other qualification. It keeps its value from the strobe's falling edge onward.
- R3: In the input role, `dout_oe` is 1 only while `sel1`=1 and `sel2`=1, measured after synchronization. In every other select combination it is 0.
- R4: In the input role, a falling strobe edge drives `srq` to 0.
- R5: In the input role, a change of the port from selected to deselected drives `srq` back to 1. If a strobe falling edge is detected in the same cycle, `srq` goes to 0 instead.
- R6: In the output role, `dout_oe` is 1 at all times, whatever the selects are.
- R7: In the output role, the register loads `din` only while `sel1`=0, `sel2`=1 and the strobe is high. In any other combination the register keeps its value.
- R8: In the output role, a change of the port from selected to deselected drives `srq` to 1, and the next strobe falling edge returns it to 0. If both are detected in the same cycle, `srq` goes to 1.
- R9: A low `clr_n` clears `dout` to 0 at once, without waiting for a clock edge. It also sets `srq` to 1 in the input role and to 0 in the output role.
- R10: A change on `strb`, `sel1` or `sel2` reaches the ports no later than `SYNC_STAGES`+1 clock edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobe and the selects |
| clr_n | input | 1 | Asynchronous active-low clear |
| mode | input | 1 | Role select: 0 for input port, 1 for output port |
| din | input | WIDTH | Parallel data in |
| strb | input | 1 | Data strobe; the register is transparent while it is high |
| sel1 | input | 1 | Select 1; its active level depends on mode |
| sel2 | input | 1 | Select 2, active high |
| dout | output | WIDTH | Register contents |
| dout_oe | output | 1 | Output enable; 0 stands for high impedance |
| srq | output | 1 | Service-request output |

## Verification
The embedded properties check on every cycle that the register changes only in a cycle where loading is allowed and then takes the sampled data. They also check the set and release rules of the request flag in both roles, including which event wins when both occur together, and that `dout_oe` stays high in the output role. Some behaviours appear only at the ports over a whole sequence, and only the directed scenarios can show them. These are:
- the asynchronous clear, checked between clock edges;
- the mode-dependent reset level of `srq`;
- the register ignoring strobes when the select combination is wrong for the role;
- the full peripheral-to-host and host-to-peripheral handshake sequences.

// File: rtl/bp_pkg.sv
package bp_pkg;

   typedef enum logic {
      PM_INPUT  = 1'b0,
      PM_OUTPUT = 1'b1
   } port_mode_e;

   // R1: select 1 polarity follows the role, select 2 is always active high
   function automatic logic port_selected(input port_mode_e m, input logic s1, input logic s2);
      logic s1_act;
      s1_act = (m == PM_OUTPUT) ? ~s1 : s1;
      return s1_act & s2;
   endfunction

endpackage

// File: rtl/bp_sync.sv
module bp_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam int LAST = STAGES - 1;

   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bp_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("bp_sync: WIDTH must be at least 1");
      end

      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain[LAST];

endmodule

// File: rtl/bp_datareg.sv
module bp_datareg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("bp_datareg: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   // R2 / R7: the value only moves in a cycle where loading was allowed
   p_hold_without_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> $stable(q));

   // R2: a load takes the sampled data
   p_load_takes_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load) |-> (q == $past(d)));

endmodule

// File: rtl/bp_hshake.sv
module bp_hshake
   import bp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  port_mode_e mode,
   input  logic       strb_s,
   input  logic       sel1_s,
   input  logic       sel2_s,
   output logic       load,
   output logic       oe,
   output logic       srq
);

   logic strb_d;
   logic sel_now;
   logic sel_d;
   logic strb_fall;
   logic desel;
   logic pend;
   logic pend_set;
   logic pend_clr;

   assign sel_now   = port_selected(mode, sel1_s, sel2_s);
   assign strb_fall = strb_d & ~strb_s;
   assign desel     = sel_d & ~sel_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_d <= 1'b0;
         sel_d  <= 1'b0;
      end else begin
         strb_d <= strb_s;
         sel_d  <= sel_now;
      end
   end

   // Load policy and set/release events swap with the role
   always_comb begin
      if (mode == PM_OUTPUT) begin
         load     = strb_s & sel_now;
         oe       = 1'b1;
         pend_set = desel;
         pend_clr = strb_fall;
      end else begin
         load     = strb_s;
         oe       = sel_now;
         pend_set = strb_fall;
         pend_clr = desel;
      end
   end

   // The flag means "a request is pending" and clears to 0 in both roles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend <= 1'b0;
      else if (pend_set) pend <= 1'b1;
      else if (pend_clr) pend <= 1'b0;
   end

   // The request drives low in the input role and high in the output role
   assign srq = (mode == PM_OUTPUT) ? pend : ~pend;

   p_fall_requests_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_INPUT && strb_fall) |=> (srq == 1'b0));

   p_deselect_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_INPUT && desel && !strb_fall) |=> (srq == 1'b1));

   p_deselect_requests_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_OUTPUT && desel) |=> (srq == 1'b1));

   p_fall_acknowledges_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_OUTPUT && strb_fall && !desel) |=> (srq == 1'b0));

   p_quiet_keeps_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_fall && !desel) |=> $stable(srq));

endmodule

// File: rtl/byte_port.sv
module byte_port
   import bp_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             mode,
   input  logic [WIDTH-1:0] din,
   input  logic             strb,
   input  logic             sel1,
   input  logic             sel2,
   output logic [WIDTH-1:0] dout,
   output logic             dout_oe,
   output logic             srq
);

   localparam int N_CTRL = 3;

   logic [N_CTRL-1:0] ctrl_async;
   logic [N_CTRL-1:0] ctrl_sync;
   logic              load;
   port_mode_e        mode_e;

   assign mode_e     = port_mode_e'(mode);
   assign ctrl_async = {sel2, sel1, strb};

   bp_sync #(
      .WIDTH  (N_CTRL),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (clr_n),
      .async_i (ctrl_async),
      .sync_o  (ctrl_sync)
   );

   bp_hshake u_hs (
      .clk    (clk),
      .rst_n  (clr_n),
      .mode   (mode_e),
      .strb_s (ctrl_sync[0]),
      .sel1_s (ctrl_sync[1]),
      .sel2_s (ctrl_sync[2]),
      .load   (load),
      .oe     (dout_oe),
      .srq    (srq)
   );

   bp_datareg #(
      .WIDTH (WIDTH)
   ) u_reg (
      .clk   (clk),
      .rst_n (clr_n),
      .load  (load),
      .d     (din),
      .q     (dout)
   );

   p_output_role_drives_r6: assert property (@(posedge clk) disable iff (!clr_n)
      (mode_e == PM_OUTPUT) |-> dout_oe);

endmodule

// File: tb/byte_port_tb.sv
module byte_port_tb;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         clr_n;
   logic         mode;
   logic [W-1:0] din;
   logic         strb;
   logic         sel1;
   logic         sel2;
   logic [W-1:0] dout;
   logic         dout_oe;
   logic         srq;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   byte_port #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
      .clk     (clk),
      .clr_n   (clr_n),
      .mode    (mode),
      .din     (din),
      .strb    (strb),
      .sel1    (sel1),
      .sel2    (sel2),
      .dout    (dout),
      .dout_oe (dout_oe),
      .srq     (srq)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // 4 negedges covers the synchronizer chain plus the output register (R10)
   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic do_clear(input logic m);
      @(negedge clk);
      clr_n = 1'b0;
      mode  = m;
      strb  = 1'b0; sel1 = m; sel2 = 1'b0; din = '0;
      #3;
      clr_n = 1'b0;
      @(negedge clk);
      clr_n = 1'b1;
      settle();
   endtask

   task automatic t_reset_input();
      do_clear(1'b0);
      chk("R9", "input srq after clear", srq, 1);
      chk("R9", "dout after clear", dout, 0);
      chk("R3", "oe while deselected", dout_oe, 0);
   endtask

   task automatic t_input_capture();
      din = 8'h5A; strb = 1'b1; settle();
      chk("R2", "dout follows din while strobe high", dout, 8'h5A);
      chk("R4", "srq before fall", srq, 1);
      strb = 1'b0; settle();
      chk("R4", "srq after strobe fall", srq, 0);
      din = 8'hFF; settle();
      chk("R2", "dout holds after fall", dout, 8'h5A);
      sel1 = 1'b1; sel2 = 1'b0; settle();
      chk("R3", "oe with only sel1", dout_oe, 0);
      chk("R10", "srq kept with partial select", srq, 0);
      sel1 = 1'b0; sel2 = 1'b1; settle();
      chk("R3", "oe with only sel2", dout_oe, 0);
      sel1 = 1'b1; sel2 = 1'b1; settle();
      chk("R3", "oe when both selects high", dout_oe, 1);
      chk("R1", "input select polarity read data", dout, 8'h5A);
      chk("R5", "srq held while selected", srq, 0);
      sel2 = 1'b0; settle();
      chk("R5", "srq after deselect", srq, 1);
      chk("R3", "oe after deselect", dout_oe, 0);
   endtask

   task automatic t_input_collision();
      din = 8'h33; sel1 = 1'b1; sel2 = 1'b1; strb = 1'b1; settle();
      strb = 1'b0; sel2 = 1'b0; settle();
      chk("R5", "fall wins over deselect in input role", srq, 0);
   endtask

   task automatic t_async_clear();
      @(negedge clk);
      #5;
      clr_n = 1'b0;
      #2;
      chk("R9", "dout cleared between edges", dout, 0);
      chk("R9", "input srq set between edges", srq, 1);
      @(negedge clk);
      clr_n = 1'b1;
   endtask

   task automatic t_output_write();
      do_clear(1'b1);
      chk("R9", "output srq after clear", srq, 0);
      chk("R6", "oe in output role while deselected", dout_oe, 1);
      sel1 = 1'b0; sel2 = 1'b1; din = 8'hA7; strb = 1'b1; settle();
      chk("R7", "write when selected", dout, 8'hA7);
      chk("R1", "output select polarity", srq, 0);
      strb = 1'b0; settle();
      din = 8'h11; settle();
      chk("R7", "hold after fall", dout, 8'hA7);
      sel2 = 1'b0; settle();
      chk("R8", "srq after deselect", srq, 1);
      strb = 1'b1; settle();
      chk("R7", "no load while sel2 low", dout, 8'hA7);
      strb = 1'b0; settle();
      chk("R8", "srq after next fall", srq, 0);
      sel1 = 1'b1; sel2 = 1'b1; din = 8'h22; strb = 1'b1; settle();
      chk("R7", "no load while sel1 high", dout, 8'hA7);
      chk("R6", "oe with sel1 high", dout_oe, 1);
      strb = 1'b0; settle();
   endtask

   task automatic t_output_collision();
      sel1 = 1'b0; sel2 = 1'b1; din = 8'h6C; strb = 1'b1; settle();
      chk("R7", "second write", dout, 8'h6C);
      strb = 1'b0; sel2 = 1'b0; settle();
      chk("R8", "deselect wins over fall in output role", srq, 1);
   endtask

   initial begin
      clr_n = 1'b0; mode = 1'b0; din = '0; strb = 1'b0; sel1 = 1'b0; sel2 = 1'b0;
      t_reset_input();
      t_input_capture();
      t_input_collision();
      t_async_clear();
      t_output_write();
      t_output_collision();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule